// File: doc/BRIEF.md
# TDM Serial Bus Frame Emulator

This block is a bus master used to exercise a time-division-multiplexed serial receiver. It runs from one fast system clock and divides it down into a bus clock, a one-cycle bit enable, a serial data line and an active-low frame pulse. Each frame carries 32 eight-bit channels, most significant bit first. At the default divide of 4, an 8.192 MHz system clock gives a 2.048 MHz bus clock, a 2.048 Mbit/s line rate and one frame every 125 microseconds.

Channel bytes are written through a simple address and data port into a staging buffer. The whole buffer is copied into a shadow copy at each frame start, so software can prepare the next frame while the current one is on the wire.

Inside the block, the transmitter raises an active-high frame strobe for the bit period before channel 0 bit 7, so the data runs one bit behind the strobe. A small retimer turns that strobe into the bus frame pulse. The pulse falls on the bus clock falling edge inside the strobe period and rises again on the bus clock rising edge that starts channel 0 bit 7. A receiver that samples the pulse on rising edges with zero data delay therefore finds bit 7 of channel 0 in the period it detects the frame. Frames only begin on a frame boundary, and only when the enable input was high at that boundary.

Top module: `tdm_frame_emu`

## Requirements
- R1: While rst_ni is low, frame_n_o is 1, sdata_o is 1 and fs_strobe_o is 0.
- R2: The bus clock period is CLK_DIV system clocks: bclk_o is high for the first CLK_DIV/2 cycles and low for the rest. bit_en_o is high for exactly the first cycle of each period, which is the cycle in which bclk_o has just risen.
- R3: Bit periods are numbered from 0, starting with the first bit_en_o pulse after reset release, which comes CLK_DIV clocks after release. Only periods whose number is 0 modulo 256 are strobe slots. fs_strobe_o is low in every other period. In a strobe slot it is high for the whole period exactly when a frame is issued.
- R4: After a strobe, sdata_o carries channel 0 bit 7 in the next bit period. Channels follow in order 0 to 31 and bits within a channel go from 7 down to 0. The line value changes only at the start of a bit period, and channel 31 bit 0 falls in the next strobe slot.
- R5: frame_n_o goes low at the bclk_o falling edge inside an issued strobe slot. It returns high at the next bclk_o rising edge and stays high at all other times.
- R6: A write with wr_en_i high stores wr_data_i into channel wr_addr_i of the staging buffer. The buffer is copied for transmission at the rising edge that begins channel 0 bit 7, so a write made during a frame first appears in the following frame.
- R7: enable_i is sampled at the clock edge that starts a strobe slot. A frame is issued only when it is high there, and raising enable_i between boundaries starts nothing before the next boundary.
- R8: When enable_i is low at a boundary, no strobe or frame pulse appears there. Any frame already in progress still completes. From the period after that boundary, sdata_o holds the idle level 1 until a frame is issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, CLK_DIV times the bit rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Allows a frame to start at the next boundary |
| wr_en_i | input | 1 | Channel byte write strobe |
| wr_addr_i | input | 5 | Channel number to write |
| wr_data_i | input | 8 | Channel byte |
| bclk_o | output | 1 | Bus clock |
| bit_en_o | output | 1 | One-cycle pulse at each bit period start |
| sdata_o | output | 1 | Serial transmit data |
| frame_n_o | output | 1 | Active-low bus frame pulse |
| fs_strobe_o | output | 1 | Internal active-high transmit frame strobe |

## Verification
If the slot counter is wrong, the strobe shows up in the wrong bit period, and this is seen at the very next boundary because the bench predicts the strobe slot from its own count of bit_en_o pulses. A bad frame-go or data-active flag shows as a missing or extra strobe, or as live data where the idle level 1 is expected, within one bit period of the boundary. Errors in the channel or bit index, or in the shadow copy, appear as a wrong bit in the serial stream. Each frame is compared bit by bit against bytes that were queued when they were written, so such an error is caught in the same bit period. A fault in the phase counter or the retimer is caught within one system cycle, because bclk_o and frame_n_o are compared on every cycle.

// File: rtl/tdm_emu_pkg.sv
package tdm_emu_pkg;
  localparam int unsigned DEF_CLK_DIV = 4;
  localparam int unsigned DEF_N_CH    = 32;
  localparam int unsigned DEF_CH_W    = 8;
  localparam logic        IDLE_LVL    = 1'b1;
endpackage

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bit_tick_o,
  output logic half_tick_o,
  output logic bclk_o,
  output logic bit_en_o
);
  localparam int unsigned PH_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int unsigned HALF = CLK_DIV / 2;

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ph_q <= '0;
    else if (ph_q == PH_W'(CLK_DIV - 1))    ph_q <= '0;
    else                                    ph_q <= ph_q + 1'b1;
  end

  // tick flags mark the edge that ends the current phase
  assign bit_tick_o  = (ph_q == PH_W'(CLK_DIV - 1));
  assign half_tick_o = (ph_q == PH_W'(HALF - 1));
  assign bclk_o      = (ph_q < PH_W'(HALF));
  assign bit_en_o    = (ph_q == '0);
endmodule

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl #(
  parameter int unsigned FRAME_BITS = 256,
  localparam int unsigned SLOT_W    = $clog2(FRAME_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              enable_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              strobe_o,
  output logic              load_o,
  output logic              act_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_BITS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic              go_q;
  logic              act_q;

  // reset one slot before the strobe slot so the first boundary follows at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= LAST - 1'b1;
      go_q   <= 1'b0;
      act_q  <= 1'b0;
    end else if (bit_tick_i) begin
      slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
      if (slot_q == LAST - 1'b1) go_q  <= enable_i;
      if (slot_q == LAST)        act_q <= go_q;
    end
  end

  assign slot_o   = slot_q;
  assign strobe_o = go_q && (slot_q == LAST);
  assign load_o   = bit_tick_i && (slot_q == LAST);
  assign act_o    = act_q;
endmodule

// File: rtl/tdm_frame_store.sv
module tdm_frame_store #(
  parameter int unsigned N_CH = 32,
  parameter int unsigned CH_W = 8,
  localparam int unsigned CH_AW = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CH_AW-1:0] wr_addr_i,
  input  logic [CH_W-1:0]  wr_data_i,
  input  logic             load_i,
  input  logic [CH_AW-1:0] rd_addr_i,
  output logic [CH_W-1:0]  rd_byte_o
);
  logic [CH_W-1:0] stage_q  [N_CH];
  logic [CH_W-1:0] shadow_q [N_CH];

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[i]  <= '0;
        shadow_q[i] <= '0;
      end else begin
        if (wr_en_i && (wr_addr_i == CH_AW'(i))) stage_q[i] <= wr_data_i;
        // same-cycle write lands in the next frame
        if (load_i) shadow_q[i] <= stage_q[i];
      end
    end
  end

  assign rd_byte_o = shadow_q[rd_addr_i];
endmodule

// File: rtl/tdm_fs_retime.sv
module tdm_fs_retime (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_tick_i,
  input  logic bit_tick_i,
  input  logic strobe_i,
  output logic frame_n_o
);
  logic frame_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        frame_n_q <= 1'b1;
    else if (half_tick_i && strobe_i)   frame_n_q <= 1'b0;
    else if (bit_tick_i)                frame_n_q <= 1'b1;
  end

  assign frame_n_o = frame_n_q;
endmodule

// File: rtl/tdm_frame_emu.sv
module tdm_frame_emu
  import tdm_emu_pkg::*;
#(
  parameter int unsigned CLK_DIV = DEF_CLK_DIV,
  parameter int unsigned N_CH    = DEF_N_CH,
  parameter int unsigned CH_W    = DEF_CH_W,
  localparam int unsigned CH_AW  = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             wr_en_i,
  input  logic [CH_AW-1:0] wr_addr_i,
  input  logic [CH_W-1:0]  wr_data_i,
  output logic             bclk_o,
  output logic             bit_en_o,
  output logic             sdata_o,
  output logic             frame_n_o,
  output logic             fs_strobe_o
);
  localparam int unsigned BIT_AW     = $clog2(CH_W);
  localparam int unsigned FRAME_BITS = N_CH * CH_W;
  localparam int unsigned SLOT_W     = $clog2(FRAME_BITS);

  logic              bit_tick, half_tick;
  logic [SLOT_W-1:0] slot;
  logic              strobe, load, data_act;
  logic [CH_W-1:0]   rd_byte;
  logic [BIT_AW-1:0] bit_sel;

  tdm_bit_timer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_tick_o (bit_tick),
    .half_tick_o(half_tick),
    .bclk_o     (bclk_o),
    .bit_en_o   (bit_en_o)
  );

  tdm_slot_ctrl #(.FRAME_BITS(FRAME_BITS)) u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_tick_i(bit_tick),
    .enable_i  (enable_i),
    .slot_o    (slot),
    .strobe_o  (strobe),
    .load_o    (load),
    .act_o     (data_act)
  );

  tdm_frame_store #(.N_CH(N_CH), .CH_W(CH_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .load_i   (load),
    .rd_addr_i(slot[SLOT_W-1:BIT_AW]),
    .rd_byte_o(rd_byte)
  );

  tdm_fs_retime u_retime (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .half_tick_i(half_tick),
    .bit_tick_i (bit_tick),
    .strobe_i   (strobe),
    .frame_n_o  (frame_n_o)
  );

  // msb first within each channel
  assign bit_sel     = BIT_AW'(CH_W - 1) - slot[BIT_AW-1:0];
  assign sdata_o     = data_act ? rd_byte[bit_sel] : IDLE_LVL;
  assign fs_strobe_o = strobe;
endmodule

// File: rtl/tdm_frame_emu_chk.sv
module tdm_frame_emu_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bclk_o,
  input logic bit_en_o,
  input logic sdata_o,
  input logic frame_n_o,
  input logic fs_strobe_o,
  input logic act_i
);
  assert_pulse_in_low_half_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_n_o |-> (!bclk_o && fs_strobe_o));

  assert_pulse_ends_on_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_n_o) |-> (bit_en_o && bclk_o));

  assert_bit_en_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_o |=> !bit_en_o);

  assert_rise_has_bit_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_o) |-> bit_en_o);

  assert_strobe_on_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fs_strobe_o) |-> bit_en_o);

  assert_data_follows_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fs_strobe_o) |-> (act_i && bit_en_o));

  assert_idle_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |-> sdata_o);
endmodule

bind tdm_frame_emu tdm_frame_emu_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bclk_o     (bclk_o),
  .bit_en_o   (bit_en_o),
  .sdata_o    (sdata_o),
  .frame_n_o  (frame_n_o),
  .fs_strobe_o(fs_strobe_o),
  .act_i      (data_act)
);

// File: tb/tdm_frame_emu_test.sv
module tdm_frame_emu_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int NCH = 32;
  localparam int FB  = NCH * 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [4:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       bclk_o, bit_en_o, sdata_o, frame_n_o, fs_strobe_o;

  tdm_frame_emu uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .bclk_o(bclk_o), .bit_en_o(bit_en_o), .sdata_o(sdata_o),
    .frame_n_o(frame_n_o), .fs_strobe_o(fs_strobe_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic en_q = 1'b0;
  logic [7:0] exp_q[$];

  always @(posedge clk_i) en_q <= enable_i;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int ch);
    return 8'((ch * 29) ^ (s * 83) ^ ((s == 2) ? 255 : 0));
  endfunction

  // driver: writes a frame (descending addresses) and queues its bytes in channel order
  task automatic load_frame(input int s);
    for (int ch = NCH - 1; ch >= 0; ch--) begin
      @(posedge clk_i); #1;
      wr_en_i = 1'b1; wr_addr_i = 5'(ch); wr_data_i = pat(s, ch);
    end
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
    for (int ch = 0; ch < NCH; ch++) exp_q.push_back(pat(s, ch));
  endtask

  // monitor
  int k = -1;
  int cyc = 0;
  bit strobe_now = 1'b0;
  bit pending = 1'b0;
  bit active = 1'b0;
  logic [7:0] cur [NCH];

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      int pos;
      int d;
      logic exp_bit;
      if (k >= 0) chk(bit_en_o == (cyc == DIV - 1), "R2 bit_en", bit_en_o, (cyc == DIV - 1));
      if (bit_en_o) begin
        k++;
        cyc = 0;
        pos = k % FB;
        strobe_now = (pos == 0) ? en_q : 1'b0;
        if (pos == 0) pending = strobe_now;
        chk(fs_strobe_o == strobe_now, (pos == 0) ? "R7 strobe at boundary" : "R3 strobe off-slot",
            fs_strobe_o, strobe_now);
        if (pos == 1) begin
          active = pending;
          if (active) begin
            if (exp_q.size() < NCH) begin
              chk(1'b0, "R6 frame issued without queued data", exp_q.size(), NCH);
              active = 1'b0;
            end else begin
              for (int ch = 0; ch < NCH; ch++) cur[ch] = exp_q.pop_front();
            end
          end
        end
        d = (pos + FB - 1) % FB;
        exp_bit = active ? cur[d / 8][7 - (d % 8)] : 1'b1;
        chk(sdata_o == exp_bit, active ? "R4 R6 data bit" : "R8 idle level", sdata_o, exp_bit);
      end else if (k >= 0) begin
        cyc++;
      end
      if (k >= 0) begin
        chk(bclk_o == (cyc < DIV / 2), "R2 bclk", bclk_o, (cyc < DIV / 2));
        chk(frame_n_o == !(strobe_now && cyc >= DIV / 2), "R5 frame pulse",
            frame_n_o, !(strobe_now && cyc >= DIV / 2));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk_i);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk_i);
    @(negedge clk_i);
    chk(frame_n_o == 1'b1, "R1 frame_n in reset", frame_n_o, 1);
    chk(sdata_o == 1'b1, "R1 sdata in reset", sdata_o, 1);
    chk(fs_strobe_o == 1'b0, "R1 strobe in reset", fs_strobe_o, 0);
    #1 rst_ni = 1'b1;
    // disabled: frame data staged, nothing may start (R7, R8)
    load_frame(0);
    repeat (300 * DIV) @(posedge clk_i);
    #1 enable_i = 1'b1;
    for (int f = 1; f <= 3; f++) begin
      @(negedge fs_strobe_o);
      load_frame(f);
    end
    @(negedge fs_strobe_o);
    repeat (100) @(posedge clk_i);
    #1 enable_i = 1'b0;
    repeat (2 * FB * DIV + 50) @(posedge clk_i);
    // restart after idle
    load_frame(4);
    #1 enable_i = 1'b1;
    @(negedge fs_strobe_o);
    repeat (50) @(posedge clk_i);
    #1 enable_i = 1'b0;
    repeat (FB * DIV + FB * DIV / 2) @(posedge clk_i);
    chk(exp_q.size() == 0, "R6 all staged frames sent", exp_q.size(), 0);
    finish_run();
  end
endmodule